// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block gathers interrupt requests from hardware sources arranged by priority level. Each level keeps a vector of pending sources and one bit in a per-level pending summary. A source posts or withdraws its request by giving a (level, index) pair. A single pulse can also wipe all pending state. A software request word provides a second set of requests. The block scans both sets at once and finds the highest resulting priority. It raises an interrupt only when that priority is above the processor's current priority level.

The processor's pipeline asks for a decision with a take strobe. On a raise, the block captures the winning priority and the summary of active levels, and sets an info-pending flag. An update strobe later copies the captured pair to the visible interrupt-ID and summary outputs and clears the flag. A separate check output tells the pipeline that something is pending and that the program counter is word aligned. Misuse never changes state: out-of-range coordinates, an update with nothing captured, and a request for the unsupported asynchronous trap. Each kind of misuse sets its own sticky error flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A post with an in-range level L and index I sets source bit (L, I), and from the next cycle bit L of `lvl_status` reads 1.
- R2: A clear of (L, I) drops that source bit; bit L of `lvl_status` returns to 0 only once no source bit of level L remains set.
- R3: When a post and a clear name the same (L, I) in one cycle, the post wins and the bit stays set; a clear-all in the same cycle overrides both.
- R4: A clear-all empties every level vector, and `lvl_status` reads all zero on the next cycle.
- R5: `irq_check` is 1 exactly when `lvl_status` is nonzero and `pc_lo` equals 2'b00.
- R6: For each software request bit i with SW_LO <= i <= SW_HI (defaults 1 and 15), the candidate priority is i - SW_LO + 1 and bit i of `cand_sum` is set; software bits outside that range are ignored.
- R7: For each set `lvl_status` bit i with EXT_LO <= i <= EXT_HI (defaults 16 and 31), the candidate priority is i and bit i of `cand_sum` is set. External levels beat software ones, and within each group the highest level wins. A pending level below EXT_LO adds no priority.
- R8: `irq_raise` is 1 exactly when `cand_ipl` is nonzero and strictly greater than `cur_ipl`.
- R9: A take strobe while `irq_raise` is 1 and `async_trap` is 0 captures `cand_ipl` and `cand_sum` and sets `info_pend`. An update strobe while `info_pend` is 1 copies them to `intid` and `isr` and clears `info_pend`.
- R10: An update strobe while `info_pend` is 0 leaves `intid` and `isr` unchanged and sets the sticky `proto_err`.
- R11: A post or clear with level >= NUM_LVL (32) or index >= SRC_W (64) changes no pending state and sets the sticky `range_err`.
- R12: A nonzero `async_trap` sets the sticky `unsup_err`, and a take strobe in that cycle captures nothing.
- R13: A synchronous active-high reset clears all pending state, the captured info, the outputs `intid` and `isr`, and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post request strobe |
| post_lvl | input | 8 | Level of the post |
| post_idx | input | 8 | Source index of the post |
| clr_vld | input | 1 | Clear request strobe |
| clr_lvl | input | 8 | Level of the clear |
| clr_idx | input | 8 | Source index of the clear |
| clr_all | input | 1 | Wipe all pending state |
| sw_req | input | 32 | Software request bits, one per level |
| pc_lo | input | 2 | Two low bits of the current program counter |
| cur_ipl | input | 5 | Current processor priority level |
| async_trap | input | 1 | Asynchronous trap request (unsupported) |
| take_req | input | 1 | Pipeline asks to take an interrupt |
| upd_strobe | input | 1 | Commit captured info to the outputs |
| lvl_status | output | 32 | Per-level pending summary |
| irq_check | output | 1 | Something pending and PC aligned |
| irq_raise | output | 1 | Candidate priority exceeds current level |
| cand_ipl | output | 5 | Highest candidate priority |
| cand_sum | output | 32 | Summary of contributing levels |
| info_pend | output | 1 | Captured info awaiting commit |
| intid | output | 5 | Committed interrupt priority |
| isr | output | 32 | Committed interrupt summary |
| range_err | output | 1 | Sticky out-of-range post or clear |
| proto_err | output | 1 | Sticky update without captured info |
| unsup_err | output | 1 | Sticky asynchronous trap request |

## Verification
Posting and clearing can hit the same source bit in the same cycle, and clear-all can arrive together with a post. The bench drives both strobes in one cycle, first with the same (level, index) pair and later with a clear-all on top. It then judges which operation prevailed by reading `lvl_status` after the edge. The take and update strobes also share cycles with the range and trap errors. The bench confirms that each error flag rises while the pending and captured state stays as it was.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Priority of a software request bit inside the software range.
  function automatic int sw_prio(int bit_i, int lo);
    return bit_i - lo + 1;
  endfunction

  // External levels carry their own index as priority.
  function automatic int ext_prio(int lvl);
    return lvl;
  endfunction

  // A (level, index) coordinate is legal when both fit the storage.
  function automatic logic coord_ok(int lvl, int idx, int nl, int ns);
    return (lvl < nl) && (idx < ns);
  endfunction

endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_pkg::*;
#(
  parameter int NUM_LVL = 32,
  parameter int SRC_W   = 64,
  parameter int LI_W    = 8,
  parameter int XI_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [LI_W-1:0]    post_lvl,
  input  logic [XI_W-1:0]    post_idx,
  input  logic               clr_vld,
  input  logic [LI_W-1:0]    clr_lvl,
  input  logic [XI_W-1:0]    clr_idx,
  input  logic               clr_all,
  output logic [NUM_LVL-1:0] lvl_status,
  output logic               range_err
);
  localparam int SIW = $clog2(SRC_W);

  logic post_ok, clr_ok, bad_req;
  logic [NUM_LVL-1:0] stat_q;
  logic [NUM_LVL-1:0] any_src;   // OR of each vector, brought out for checking
  logic range_err_q;

  assign post_ok = post_vld && coord_ok(int'(post_lvl), int'(post_idx), NUM_LVL, SRC_W);
  assign clr_ok  = clr_vld  && coord_ok(int'(clr_lvl),  int'(clr_idx),  NUM_LVL, SRC_W);
  assign bad_req = (post_vld && !post_ok) || (clr_vld && !clr_ok);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [SRC_W-1:0] vec_q, set_m, clr_m, nxt;

    always_comb begin
      set_m = '0;
      clr_m = '0;
      if (post_ok && post_lvl == LI_W'(l)) set_m[post_idx[SIW-1:0]] = 1'b1;
      if (clr_ok && clr_lvl == LI_W'(l))   clr_m[clr_idx[SIW-1:0]]  = 1'b1;
      // post wins over clear on the same bit; clear-all wins over both
      nxt = clr_all ? '0 : ((vec_q & ~clr_m) | set_m);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vec_q     <= '0;
        stat_q[l] <= 1'b0;
      end else begin
        vec_q <= nxt;
        if (clr_all)                          stat_q[l] <= 1'b0;
        else if (|set_m)                      stat_q[l] <= 1'b1;
        else if ((|clr_m) && (nxt == '0))     stat_q[l] <= 1'b0;
      end
    end

    assign any_src[l] = |vec_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          range_err_q <= 1'b0;
    else if (bad_req) range_err_q <= 1'b1;
  end

  assign lvl_status = stat_q;
  assign range_err  = range_err_q;

  // R1/R2: status word kept in step with the source vectors
  a_r2_status_consistent: assert property (@(posedge clk) disable iff (rst)
    lvl_status == any_src);

  // R4: clear-all empties everything
  a_r4_clear_all_empties: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (lvl_status == '0));

  // R11: illegal coordinates raise the flag and leave the status alone
  a_r11_bad_post_flags: assert property (@(posedge clk) disable iff (rst)
    (post_vld && !post_ok && !clr_vld && !clr_all) |=> (range_err && $stable(lvl_status)));

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_pkg::*;
#(
  parameter int NUM_LVL = 32,
  parameter int IPL_W   = 5,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31
) (
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [NUM_LVL-1:0] status,
  output logic [IPL_W-1:0]   ipl,
  output logic [NUM_LVL-1:0] sum
);
  // Software first, external after: the last hit in ascending order wins.
  always_comb begin
    ipl = '0;
    sum = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req[i]) begin
        ipl    = IPL_W'(sw_prio(i, SW_LO));
        sum[i] = 1'b1;
      end
    end
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (status[i]) begin
        ipl    = IPL_W'(ext_prio(i));
        sum[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_info_latch.sv
module irq_info_latch #(
  parameter int NUM_LVL = 32,
  parameter int IPL_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_req,
  input  logic               upd_strobe,
  input  logic               raise,
  input  logic               async_trap,
  input  logic [IPL_W-1:0]   cand_ipl,
  input  logic [NUM_LVL-1:0] cand_sum,
  output logic               info_pend,
  output logic [IPL_W-1:0]   intid,
  output logic [NUM_LVL-1:0] isr,
  output logic               proto_err,
  output logic               unsup_err
);
  logic               pend_q, perr_q, uerr_q;
  logic [IPL_W-1:0]   lat_ipl, id_q;
  logic [NUM_LVL-1:0] lat_sum, isr_q;
  logic               do_take, do_commit;

  assign do_take   = take_req && raise && !async_trap;
  assign do_commit = upd_strobe && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      lat_ipl <= '0;
      lat_sum <= '0;
      id_q    <= '0;
      isr_q   <= '0;
      perr_q  <= 1'b0;
      uerr_q  <= 1'b0;
    end else begin
      if (do_commit) begin
        id_q   <= lat_ipl;
        isr_q  <= lat_sum;
        pend_q <= 1'b0;
      end
      if (do_take) begin
        lat_ipl <= cand_ipl;
        lat_sum <= cand_sum;
        pend_q  <= 1'b1;
      end
      if (upd_strobe && !pend_q) perr_q <= 1'b1;
      if (async_trap)            uerr_q <= 1'b1;
    end
  end

  assign info_pend = pend_q;
  assign intid     = id_q;
  assign isr       = isr_q;
  assign proto_err = perr_q;
  assign unsup_err = uerr_q;

  a_r9_take_sets_pend: assert property (@(posedge clk) disable iff (rst)
    (take_req && raise && !async_trap) |=> info_pend);

  a_r9_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && info_pend && !take_req) |=> !info_pend);

  a_r10_idle_update: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && !info_pend) |=> (proto_err && $stable(intid) && $stable(isr)));

  a_r12_trap_blocks: assert property (@(posedge clk) disable iff (rst)
    (async_trap && !info_pend) |=> (unsup_err && !info_pend));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_LVL = 32,
  parameter int SRC_W   = 64,
  parameter int LI_W    = 8,
  parameter int XI_W    = 8,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31,
  localparam int IPL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [LI_W-1:0]    post_lvl,
  input  logic [XI_W-1:0]    post_idx,
  input  logic               clr_vld,
  input  logic [LI_W-1:0]    clr_lvl,
  input  logic [XI_W-1:0]    clr_idx,
  input  logic               clr_all,
  input  logic [NUM_LVL-1:0] sw_req,
  input  logic [1:0]         pc_lo,
  input  logic [IPL_W-1:0]   cur_ipl,
  input  logic               async_trap,
  input  logic               take_req,
  input  logic               upd_strobe,
  output logic [NUM_LVL-1:0] lvl_status,
  output logic               irq_check,
  output logic               irq_raise,
  output logic [IPL_W-1:0]   cand_ipl,
  output logic [NUM_LVL-1:0] cand_sum,
  output logic               info_pend,
  output logic [IPL_W-1:0]   intid,
  output logic [NUM_LVL-1:0] isr,
  output logic               range_err,
  output logic               proto_err,
  output logic               unsup_err
);
  logic [NUM_LVL-1:0] stat_w;
  logic [IPL_W-1:0]   ipl_w;
  logic [NUM_LVL-1:0] sum_w;
  logic               raise_w;

  irq_pend_store #(.NUM_LVL(NUM_LVL), .SRC_W(SRC_W), .LI_W(LI_W), .XI_W(XI_W)) u_store (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
    .clr_all(clr_all), .lvl_status(stat_w), .range_err(range_err)
  );

  irq_prio_scan #(.NUM_LVL(NUM_LVL), .IPL_W(IPL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
                  .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_scan (
    .sw_req(sw_req), .status(stat_w), .ipl(ipl_w), .sum(sum_w)
  );

  assign raise_w = (ipl_w != '0) && (ipl_w > cur_ipl);

  irq_info_latch #(.NUM_LVL(NUM_LVL), .IPL_W(IPL_W)) u_info (
    .clk(clk), .rst(rst), .take_req(take_req), .upd_strobe(upd_strobe),
    .raise(raise_w), .async_trap(async_trap), .cand_ipl(ipl_w), .cand_sum(sum_w),
    .info_pend(info_pend), .intid(intid), .isr(isr),
    .proto_err(proto_err), .unsup_err(unsup_err)
  );

  assign lvl_status = stat_w;
  assign irq_check  = (stat_w != '0) && (pc_lo == 2'b00);
  assign irq_raise  = raise_w;
  assign cand_ipl   = ipl_w;
  assign cand_sum   = sum_w;

  // R7: any pending external level forces an external-range priority
  a_r7_ext_dominates: assert property (@(posedge clk) disable iff (rst)
    (|stat_w[EXT_HI:EXT_LO]) |-> (cand_ipl >= IPL_W'(EXT_LO)));

  // R5: check output only with aligned PC and something pending
  a_r5_check_aligned: assert property (@(posedge clk) disable iff (rst)
    irq_check |-> ((pc_lo == 2'b00) && (lvl_status != '0)));

  // R9: captured info never commits a priority the pipeline could not raise
  a_r9_commit_nonzero: assert property (@(posedge clk) disable iff (rst)
    $past(upd_strobe && info_pend) |-> (intid != '0));

endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        post_vld, clr_vld, clr_all, async_trap, take_req, upd_strobe;
  logic [7:0]  post_lvl, post_idx, clr_lvl, clr_idx;
  logic [31:0] sw_req;
  logic [1:0]  pc_lo;
  logic [4:0]  cur_ipl;
  logic [31:0] lvl_status, cand_sum, isr;
  logic        irq_check, irq_raise, info_pend, range_err, proto_err, unsup_err;
  logic [4:0]  cand_ipl, intid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_lvl(post_lvl), .post_idx(post_idx),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_idx(clr_idx), .clr_all(clr_all),
    .sw_req(sw_req), .pc_lo(pc_lo), .cur_ipl(cur_ipl), .async_trap(async_trap),
    .take_req(take_req), .upd_strobe(upd_strobe), .lvl_status(lvl_status),
    .irq_check(irq_check), .irq_raise(irq_raise), .cand_ipl(cand_ipl), .cand_sum(cand_sum),
    .info_pend(info_pend), .intid(intid), .isr(isr), .range_err(range_err),
    .proto_err(proto_err), .unsup_err(unsup_err)
  );

  typedef struct packed {
    logic [31:0] sw;
    logic [4:0]  cur;
    logic [4:0]  ipl;
    logic        raise;
    logic [31:0] sum;
  } vec_t;

  // software-only priority vectors (no hardware level pending)
  localparam vec_t TBL [6] = '{
    '{32'h0000_0000, 5'd0, 5'd0,  1'b0, 32'h0000_0000},
    '{32'h0000_0002, 5'd0, 5'd1,  1'b1, 32'h0000_0002},
    '{32'h0000_8008, 5'd0, 5'd15, 1'b1, 32'h0000_8008},
    '{32'h0000_0008, 5'd3, 5'd3,  1'b0, 32'h0000_0008},
    '{32'h0000_0008, 5'd2, 5'd3,  1'b1, 32'h0000_0008},
    '{32'h0010_0001, 5'd0, 5'd0,  1'b0, 32'h0000_0000}
  };

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    post_vld = 0; clr_vld = 0; clr_all = 0;
    take_req = 0; upd_strobe = 0; async_trap = 0;
  endtask

  task automatic do_post(int l, int i);
    post_vld = 1; post_lvl = 8'(l); post_idx = 8'(i); tick();
  endtask

  task automatic do_clr(int l, int i);
    clr_vld = 1; clr_lvl = 8'(l); clr_idx = 8'(i); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1; post_vld = 0; clr_vld = 0; clr_all = 0; async_trap = 0;
    take_req = 0; upd_strobe = 0; post_lvl = 0; post_idx = 0;
    clr_lvl = 0; clr_idx = 0; sw_req = 0; pc_lo = 0; cur_ipl = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R13 reset state
    chk("R13 status", 64'(lvl_status), 64'h0);
    chk("R13 intid", 64'(intid), 64'h0);
    chk("R13 errs", 64'({range_err, proto_err, unsup_err, info_pend}), 64'h0);
    chk("R5 idle check", 64'(irq_check), 64'h0);

    // R6/R8 table walk
    for (int k = 0; k < 6; k++) begin
      sw_req = TBL[k].sw; cur_ipl = TBL[k].cur; #1;
      chk("R6 ipl", 64'(cand_ipl), 64'(TBL[k].ipl));
      chk("R6 sum", 64'(cand_sum), 64'(TBL[k].sum));
      chk("R8 raise", 64'(irq_raise), 64'(TBL[k].raise));
    end
    sw_req = 0; cur_ipl = 0;

    // R1/R7 external post
    do_post(20, 5);
    chk("R1 status", 64'(lvl_status), 64'h0010_0000);
    chk("R7 ipl", 64'(cand_ipl), 64'd20);
    chk("R7 sum", 64'(cand_sum), 64'h0010_0000);
    chk("R5 check aligned", 64'(irq_check), 64'h1);
    pc_lo = 2'b01; #1 chk("R5 check misaligned 01", 64'(irq_check), 64'h0);
    pc_lo = 2'b10; #1 chk("R5 check misaligned 10", 64'(irq_check), 64'h0);
    pc_lo = 2'b00;
    sw_req = 32'h0000_8000; #1;
    chk("R7 ext beats sw", 64'(cand_ipl), 64'd20);
    chk("R7 mixed sum", 64'(cand_sum), 64'h0010_8000);
    sw_req = 0;

    // R2 last source clear
    do_post(20, 9);
    do_clr(20, 5);
    chk("R2 level held", 64'(lvl_status), 64'h0010_0000);
    do_clr(20, 9);
    chk("R2 level dropped", 64'(lvl_status), 64'h0);
    chk("R5 empty check", 64'(irq_check), 64'h0);

    // R3 same-bit post and clear
    post_vld = 1; post_lvl = 18; post_idx = 7;
    clr_vld = 1; clr_lvl = 18; clr_idx = 7; tick();
    chk("R3 post wins", 64'(lvl_status), 64'h0004_0000);
    do_clr(18, 7);
    chk("R2 clear after", 64'(lvl_status), 64'h0);

    // R7 hardware level in software range adds no priority
    do_post(5, 0);
    chk("R1 low level", 64'(lvl_status), 64'h0000_0020);
    chk("R5 low check", 64'(irq_check), 64'h1);
    chk("R7 low ipl", 64'(cand_ipl), 64'h0);

    // R11 out of range
    do_post(40, 0);
    chk("R11 flag", 64'(range_err), 64'h1);
    chk("R11 no change", 64'(lvl_status), 64'h0000_0020);
    do_post(3, 64);
    chk("R11 idx no change", 64'(lvl_status), 64'h0000_0020);

    // R4 / R3 clear-all wins
    do_post(25, 63);
    do_post(17, 1);
    clr_all = 1; post_vld = 1; post_lvl = 30; post_idx = 0; tick();
    chk("R4 clear all", 64'(lvl_status), 64'h0);
    chk("R3 clear all over post", 64'(cand_ipl), 64'h0);

    // R9 take/commit
    do_post(20, 5);
    cur_ipl = 25; #1;
    chk("R8 below cur", 64'(irq_raise), 64'h0);
    take_req = 1; tick();
    chk("R9 no take", 64'(info_pend), 64'h0);
    cur_ipl = 0; take_req = 1; tick();
    chk("R9 pend set", 64'(info_pend), 64'h1);
    chk("R9 not yet", 64'(intid), 64'h0);
    upd_strobe = 1; tick();
    chk("R9 intid", 64'(intid), 64'd20);
    chk("R9 isr", 64'(isr), 64'h0010_0000);
    chk("R9 pend clr", 64'(info_pend), 64'h0);

    // R10 stray update
    chk("R10 before", 64'(proto_err), 64'h0);
    upd_strobe = 1; tick();
    chk("R10 flag", 64'(proto_err), 64'h1);
    chk("R10 intid kept", 64'(intid), 64'd20);

    // R12 async trap
    async_trap = 1; take_req = 1; tick();
    chk("R12 flag", 64'(unsup_err), 64'h1);
    chk("R12 no capture", 64'(info_pend), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule